// File: doc/BRIEF.md
# Polled Memory-Mapped Device Port

This block sits between a simple processor load/store bus and main memory. Every bus access whose upper sixteen address bits are all ones is claimed by the block and steered to its device registers. Every other access is forwarded to the memory port without change. Inside the claimed window there are exactly two registers: a status/control word and a data word.

The device side raises a single ready condition, with a one-cycle pulse, when it has a word for the processor or can take one from it. Software can spin on the status word until ready reads as one, then load or store the data word. That data access consumes the event and drops ready. Software can instead set the interrupt-enable bit and wait for the interrupt request. The request follows ready for as long as the enable bit is set. A load of the data word returns the device's input word in the same cycle and pulses an acknowledge to the device. A store to the data word presents the stored value to the device with a one-cycle valid pulse.

Top module: `mmio_poll_port`

## Requirements
- R1: An access whose address has bits 31..16 equal to 0xFFFF never asserts memRead or memWrite. Any other access drives memAddr, memWdata, memRead and memWrite equal to the bus inputs in the same cycle, and cpuRdata equals memRdata.
- R2: A load at 0xFFFF0000 returns the status word in the same cycle: bit 0 is ready, bit 1 is interrupt-enable, and all other bits are zero.
- R3: A devSetReady pulse makes ready read as 1 from the next cycle. Ready holds its value in any cycle with no set pulse and no data-word access.
- R4: A load at 0xFFFF0004 returns devRdData in the same cycle, clears ready from the next cycle, and pulses devRdAck high for exactly the following cycle.
- R5: A store at 0xFFFF0004 drives the stored value on devWrData with devWrValid high for exactly the following cycle, and clears ready from the next cycle.
- R6: A store at 0xFFFF0000 loads interrupt-enable from bit 1 of the stored value. Bit 0 of that store has no effect on ready.
- R7: irq is high exactly when ready and interrupt-enable are both 1. Once raised, it stays high until a data-word access or a store that clears the enable bit.
- R8: When devSetReady and a data-word access fall in the same cycle, ready is 1 in the next cycle.
- R9: Loads at any other address inside the window return zero. Stores there change neither ready nor interrupt-enable, and neither kind of access produces a device pulse.
- R10: After reset, ready, interrupt-enable, irq, devWrValid and devRdAck are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 32 | Bus byte address |
| cpuRead | input | 1 | Bus load request |
| cpuWrite | input | 1 | Bus store request |
| cpuWdata | input | 32 | Bus store data |
| cpuRdata | output | 32 | Bus load data (memory or register) |
| memAddr | output | 32 | Forwarded address |
| memRead | output | 1 | Forwarded load request |
| memWrite | output | 1 | Forwarded store request |
| memWdata | output | 32 | Forwarded store data |
| memRdata | input | 32 | Memory load data |
| devSetReady | input | 1 | Device pulse: a transfer may proceed |
| devRdData | input | 32 | Device input word |
| devRdAck | output | 1 | Pulse: the input word was consumed |
| devWrData | output | 32 | Output word for the device |
| devWrValid | output | 1 | Pulse: devWrData holds a new word |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that the bus never asserts cpuRead and cpuWrite in the same cycle. They also assume that bus and device inputs are stable around the rising edge. The bench changes stimulus only on the falling edge and issues one operation per cycle: idle, load or store. It sweeps every combination of prior ready, prior enable, set pulse and operation over a fixed list of addresses inside and outside the window. A reference model in the bench computes every expected output from the requirements.

// File: rtl/mmio_poll_pkg.sv
package mmio_poll_pkg;

  // Strobes the decoder hands to the register datapath each cycle.
  typedef struct packed {
    logic winHit;   // access falls in the device window
    logic ctrlRd;   // load of the status word
    logic ctrlWr;   // store to the status word
    logic dataRd;   // load of the data word
    logic dataWr;   // store to the data word
  } portStrobes_t;

  // Status word bit positions decoded by software.
  localparam int READY_BIT = 0;
  localparam int IE_BIT    = 1;

endpackage

// File: rtl/mmio_poll_ctrl.sv
module mmio_poll_ctrl
  import mmio_poll_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_HI_W = 16,
  parameter int CTRL_OFF = 0,
  parameter int DATA_OFF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRead,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  output portStrobes_t      strb
);

  localparam int OFF_W = ADDR_W - WIN_HI_W;
  localparam logic [OFF_W-1:0] CTRL_ADDR = OFF_W'(CTRL_OFF);
  localparam logic [OFF_W-1:0] DATA_ADDR = OFF_W'(DATA_OFF);

  logic [WIN_HI_W-1:0] winTag;
  logic [OFF_W-1:0]    offset;
  logic                hit;
  logic                isCtrl;
  logic                isData;

  assign winTag = cpuAddr[ADDR_W-1 -: WIN_HI_W];
  assign offset = cpuAddr[OFF_W-1:0];
  assign hit    = &winTag;
  assign isCtrl = hit && (offset == CTRL_ADDR);
  assign isData = hit && (offset == DATA_ADDR);

  always_comb begin
    strb        = '0;
    strb.winHit = hit;
    strb.ctrlRd = isCtrl && cpuRead;
    strb.ctrlWr = isCtrl && cpuWrite;
    strb.dataRd = isData && cpuRead;
    strb.dataWr = isData && cpuWrite;
  end

  // Pass-through toward memory; requests are blocked inside the window.
  assign memAddr  = cpuAddr;
  assign memWdata = cpuWdata;
  assign memRead  = cpuRead  && !hit;
  assign memWrite = cpuWrite && !hit;

  AST_WIN_BLOCKS_MEM: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1:OFF_W] == {WIN_HI_W{1'b1}}) |-> (!memRead && !memWrite)); // R1

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ctrlRd, strb.ctrlWr, strb.dataRd, strb.dataWr})); // R9

endmodule

// File: rtl/mmio_poll_dp.sv
module mmio_poll_dp
  import mmio_poll_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobes_t      strb,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              devSetReady,
  input  logic [DATA_W-1:0] devRdData,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              devRdAck,
  output logic [DATA_W-1:0] devWrData,
  output logic              devWrValid,
  output logic              irq
);

  logic              readyQ;
  logic              ieQ;
  logic              readyNext;
  logic              ieNext;
  logic              dataAccess;
  logic [DATA_W-1:0] statusWord;

  assign dataAccess = strb.dataRd || strb.dataWr;

  // The device's set has priority over a consuming access.
  always_comb begin
    readyNext = readyQ;
    if (dataAccess)  readyNext = 1'b0;
    if (devSetReady) readyNext = 1'b1;
  end

  always_comb begin
    ieNext = ieQ;
    if (strb.ctrlWr) ieNext = cpuWdata[IE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ     <= 1'b0;
      ieQ        <= 1'b0;
      devWrValid <= 1'b0;
      devRdAck   <= 1'b0;
      devWrData  <= '0;
    end else begin
      readyQ     <= readyNext;
      ieQ        <= ieNext;
      devWrValid <= strb.dataWr;
      devRdAck   <= strb.dataRd;
      if (strb.dataWr) devWrData <= cpuWdata;
    end
  end

  always_comb begin
    statusWord            = '0;
    statusWord[READY_BIT] = readyQ;
    statusWord[IE_BIT]    = ieQ;
  end

  always_comb begin
    if (!strb.winHit)     cpuRdata = memRdata;
    else if (strb.ctrlRd) cpuRdata = statusWord;
    else if (strb.dataRd) cpuRdata = devRdData;
    else                  cpuRdata = '0;
  end

  assign irq = readyQ && ieQ;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    devSetReady |=> readyQ); // R8

  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (dataAccess && !devSetReady) |=> !readyQ); // R4

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!dataAccess && !devSetReady) |=> $stable(readyQ)); // R3

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !dataAccess && !strb.ctrlWr) |=> irq); // R7

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> (devWrValid && devWrData == $past(cpuWdata))); // R5

  AST_RD_ACK: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataRd |=> devRdAck); // R4

endmodule

// File: rtl/mmio_poll_port.sv
module mmio_poll_port
  import mmio_poll_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_HI_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRead,
  input  logic              cpuWrite,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              devSetReady,
  input  logic [DATA_W-1:0] devRdData,
  output logic              devRdAck,
  output logic [DATA_W-1:0] devWrData,
  output logic              devWrValid,
  output logic              irq
);

  portStrobes_t strb;

  mmio_poll_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .WIN_HI_W (WIN_HI_W),
    .CTRL_OFF (0),
    .DATA_OFF (4)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuAddr  (cpuAddr),
    .cpuRead  (cpuRead),
    .cpuWrite (cpuWrite),
    .cpuWdata (cpuWdata),
    .memAddr  (memAddr),
    .memRead  (memRead),
    .memWrite (memWrite),
    .memWdata (memWdata),
    .strb     (strb)
  );

  mmio_poll_dp #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cpuWdata    (cpuWdata),
    .memRdata    (memRdata),
    .devSetReady (devSetReady),
    .devRdData   (devRdData),
    .cpuRdata    (cpuRdata),
    .devRdAck    (devRdAck),
    .devWrData   (devWrData),
    .devWrValid  (devWrValid),
    .irq         (irq)
  );

endmodule

// File: tb/mmio_poll_port_bench.sv
module mmio_poll_port_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cpuAddr = '0;
  logic        cpuRead = 1'b0;
  logic        cpuWrite = 1'b0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic [31:0] memAddr;
  logic        memRead;
  logic        memWrite;
  logic [31:0] memWdata;
  logic [31:0] memRdata;
  logic        devSetReady = 1'b0;
  logic [31:0] devRdData = '0;
  logic        devRdAck;
  logic [31:0] devWrData;
  logic        devWrValid;
  logic        irq;

  int nChecks = 0;
  int nErrs   = 0;
  bit done    = 1'b0;

  // Bench model state
  logic mReady = 1'b0;
  logic mIe    = 1'b0;

  always #2 clk = ~clk;   // 4 ns period

  assign memRdata = ~memAddr ^ 32'h0F0F_0000;

  mmio_poll_port u_mmio_poll_port (
    .clk(clk), .rstN(rstN),
    .cpuAddr(cpuAddr), .cpuRead(cpuRead), .cpuWrite(cpuWrite),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .memAddr(memAddr), .memRead(memRead), .memWrite(memWrite),
    .memWdata(memWdata), .memRdata(memRdata),
    .devSetReady(devSetReady), .devRdData(devRdData), .devRdAck(devRdAck),
    .devWrData(devWrData), .devWrValid(devWrValid), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One bus operation per cycle: drive at negedge, check combinational
  // outputs, then check registered outputs after the rising edge.
  task automatic busOp(input logic rd, input logic wr, input logic [31:0] a,
                       input logic [31:0] wd, input logic setRdy);
    logic        hit;
    logic [15:0] off;
    logic [31:0] expRd;
    logic        nReady;
    logic        nIe;
    @(negedge clk);
    cpuAddr     = a;
    cpuRead     = rd;
    cpuWrite    = wr;
    cpuWdata    = wd;
    devSetReady = setRdy;
    devRdData   = a ^ 32'h5A5A_1234 ^ wd;
    #1;
    hit = (a[31:16] == 16'hFFFF);
    off = a[15:0];
    chk("R1 memRead",  {31'b0, memRead},  {31'b0, rd && !hit});
    chk("R1 memWrite", {31'b0, memWrite}, {31'b0, wr && !hit});
    if (!hit) begin
      chk("R1 memAddr", memAddr, a);
      chk("R1 memWdata", memWdata, wd);
    end
    if (rd) begin
      if (!hit)             expRd = ~a ^ 32'h0F0F_0000;
      else if (off == 16'h0) expRd = {30'b0, mIe, mReady};
      else if (off == 16'h4) expRd = devRdData;
      else                   expRd = 32'h0;
      if (!hit)              chk("R1 cpuRdata", cpuRdata, expRd);
      else if (off == 16'h0) chk("R2 status word", cpuRdata, expRd);
      else if (off == 16'h4) chk("R4 data load", cpuRdata, expRd);
      else                   chk("R9 unmapped load", cpuRdata, expRd);
    end
    nReady = mReady;
    if (hit && off == 16'h4 && (rd || wr)) nReady = 1'b0;
    if (setRdy) nReady = 1'b1;
    nIe = mIe;
    if (hit && off == 16'h0 && wr) nIe = wd[1];
    @(posedge clk);
    #1;
    mReady = nReady;
    mIe    = nIe;
    chk("R7 irq", {31'b0, irq}, {31'b0, mReady && mIe});
    chk("R5 devWrValid", {31'b0, devWrValid}, {31'b0, hit && off == 16'h4 && wr});
    chk("R4 devRdAck", {31'b0, devRdAck}, {31'b0, hit && off == 16'h4 && rd});
    if (hit && off == 16'h4 && wr) chk("R5 devWrData", devWrData, wd);
  endtask

  // Read the status word and compare to the model (checks R3/R6/R8/R9 state).
  task automatic statusCheck(input string tag);
    @(negedge clk);
    cpuAddr = 32'hFFFF_0000; cpuRead = 1'b1; cpuWrite = 1'b0; devSetReady = 1'b0;
    #1;
    chk(tag, cpuRdata, {30'b0, mIe, mReady});
    @(posedge clk);
    #1;
  endtask

  logic [31:0] addrList [8];

  initial begin
    addrList[0] = 32'hFFFF_0000;
    addrList[1] = 32'hFFFF_0004;
    addrList[2] = 32'hFFFF_0008;
    addrList[3] = 32'hFFFF_000C;
    addrList[4] = 32'hFFFF_FFFC;
    addrList[5] = 32'hFFFF_0010;
    addrList[6] = 32'h0000_1000;
    addrList[7] = 32'hFFFE_FFFC;

    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 irq", {31'b0, irq}, 32'h0);
    chk("R10 devWrValid", {31'b0, devWrValid}, 32'h0);
    chk("R10 devRdAck", {31'b0, devRdAck}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    statusCheck("R10 status after reset");

    // R6: bit 0 of a status store does not touch ready
    busOp(1'b0, 1'b1, 32'hFFFF_0000, 32'h0000_0001, 1'b0);
    statusCheck("R6 ready bit ignored");
    busOp(1'b0, 1'b1, 32'hFFFF_0000, 32'hFFFF_FFFF, 1'b0);
    statusCheck("R6 enable set");
    busOp(1'b0, 1'b0, 32'h0, 32'h0, 1'b1);
    statusCheck("R3 ready rises");
    busOp(1'b0, 1'b0, 32'h0, 32'h0, 1'b0);
    chk("R7 irq held", {31'b0, irq}, 32'h1);

    // Near-exhaustive sweep
    for (int pre = 0; pre < 2; pre++) begin
      for (int ie = 0; ie < 2; ie++) begin
        for (int s = 0; s < 2; s++) begin
          for (int op = 0; op < 3; op++) begin
            for (int ai = 0; ai < 8; ai++) begin
              logic [31:0] wd;
              // establish prior state: consume ready, set enable, maybe set ready
              busOp(1'b1, 1'b0, 32'hFFFF_0004, 32'h0, 1'b0);
              busOp(1'b0, 1'b1, 32'hFFFF_0000, {30'b0, ie[0], 1'b0}, pre[0]);
              wd = {ai[7:0], op[7:0], 8'hC3, s[0], ie[0], pre[0], 5'h0} ^ 32'h0000_0002;
              busOp(op == 1, op == 2, addrList[ai], wd, s[0]);
              statusCheck((s == 1 && ai == 1 && op != 0) ? "R8 set wins" :
                          (ai >= 2 && ai <= 5) ? "R9 no side effect" : "R3 ready state");
            end
          end
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      nErrs++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
      $finish;
    end
  end

endmodule